// File: doc/BRIEF.md
# Epoch-Based Hot Micro-Page Tracker

The tracker snoops the request stream of a memory controller and counts accesses per 1 KB micro-page over a window of controller clock cycles. Software sets the window length. The low ten bits of each request's physical address are dropped, and the rest form the micro-page number. That number is counted in a small fully associative table of candidates. The four micro-pages of a 4 KB OS page are counted as separate items.

When a window ends, the block pulses a flag and switches to a second, empty table so that counting goes on. It then streams the most frequently used micro-pages of the finished window, hottest first, over a valid/ready port. A migration engine or software collects these entries and packs the pages into a reserved DRAM region. The number of entries sent per window is capped by a parameter that stands for the reserved region's capacity. After the last entry is taken, the drained table is cleared, ready for the next swap.

Top module: `hot_page_tracker`

## Requirements
- R1: The micro-page number of a request is `req_addr[ADDR_W-1:10]`. Requests that differ only in bits [9:0] count against the same entry, and the four micro-pages of one 4 KB page count against four different entries.
- R2: A request whose micro-page is already in the live table adds one to that entry's count.
- R3: A request that misses while the live table has an empty slot fills the lowest-indexed empty slot with a count of 1.
- R4: A request that misses while all ENTRIES slots are occupied replaces the entry with the smallest count, choosing the lowest index on a tie, and the new entry starts at a count of 1.
- R5: Counts saturate at 2^CNT_W-1 and never wrap.
- R6: The window timer advances once per cycle from 0. The cycle in which it reaches `epoch_len`-1 closes the window, and a request in that cycle still counts in the closing window. `epoch_done` is high for exactly the one cycle after that edge. A value of 0 behaves like 1.
- R7: After a window closes, the entries of the closed table are delivered in order of non-increasing count, with the lower table index first among equal counts. At most HOT_MAX entries are delivered. `hot_last` marks the final one.
- R8: While `hot_valid` is high and `hot_ready` is low, `hot_valid`, `hot_page`, `hot_count` and `hot_last` hold their values.
- R9: Requests that arrive while the readout is in progress are counted toward the new window. Their entries appear in the next window's report.
- R10: While a readout is still pending, the timer holds at its final value and the window stays open, keeping on counting, until the last entry has been taken.
- R11: A synchronous high `rst` empties both tables, zeroes the timer and drops `hot_valid` and `epoch_done` on the next cycle.
- R12: A window with no requests closes with `epoch_done` but delivers no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| epoch_len | input | EPOCH_W | Window length in cycles |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | ADDR_W | Physical address of the request |
| epoch_done | output | 1 | One-cycle pulse after a window closes |
| hot_valid | output | 1 | Readout entry is valid |
| hot_ready | input | 1 | Consumer takes the readout entry |
| hot_page | output | ADDR_W-10 | Micro-page number of the entry |
| hot_count | output | CNT_W | Access count of the entry |
| hot_last | output | 1 | Entry is the final one of this readout |

## Verification
Directed windows cover several cases. Same-page offsets and sibling micro-pages separate address truncation from page aggregation. An over-full set of pages exposes which victim is evicted. One long window saturates a counter, and idle windows produce empty reports. A stalled consumer keeps the readout pending across a window end, which checks both the stretched window and that requests reaching the shadow table are kept. A long constrained-random run uses a skewed pool of 14 pages against 8 entries and a randomly throttled `hot_ready`. It produces many ties and evictions, and it compares each delivered entry and each `epoch_done` pulse against a bench model of the table and the timer.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int unsigned MICRO_PAGE_BYTES = 1024;
  localparam int unsigned MP_OFFSET_W      = $clog2(MICRO_PAGE_BYTES);

  typedef enum logic [1:0] {
    UPD_NONE,
    UPD_HIT,
    UPD_FILL,
    UPD_EVICT
  } upd_kind_e;
endpackage

// File: rtl/hpt_epoch_timer.sv
module hpt_epoch_timer #(
  parameter int EPOCH_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EPOCH_W-1:0] len,
  input  logic               hold,
  output logic               tick
);
  logic [EPOCH_W-1:0] cnt;
  logic [EPOCH_W:0]   cnt_next;
  logic               at_end;

  assign cnt_next = {1'b0, cnt} + 1'b1;
  assign at_end   = cnt_next >= {1'b0, len};
  assign tick     = at_end && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else if (!at_end) begin
      cnt <= cnt_next[EPOCH_W-1:0];
    end
  end
endmodule

// File: rtl/hpt_count_bank.sv
module hpt_count_bank
  import hpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PN_W    = 22,
  parameter int CNT_W   = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           upd_en,
  input  logic [PN_W-1:0]                upd_page,
  output logic [ENTRIES-1:0]             ent_valid,
  output logic [ENTRIES-1:0][PN_W-1:0]   ent_page,
  output logic [ENTRIES-1:0][CNT_W-1:0]  ent_count
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [ENTRIES-1:0] hit;
  logic [IW-1:0]      hit_idx, free_idx, vic_idx, tgt_idx;
  logic               hit_any, free_any;
  upd_kind_e          kind;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hit[g] = ent_valid[g] && (ent_page[g] == upd_page);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    hit_any  = 1'b0;
    free_any = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        hit_idx = i[IW-1:0];
        hit_any = 1'b1;
      end
      if (!ent_valid[i]) begin
        free_idx = i[IW-1:0];
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 1; i < ENTRIES; i++) begin
      if (ent_count[i] < ent_count[vic_idx]) vic_idx = i[IW-1:0];
    end
  end

  always_comb begin
    if (!upd_en) begin
      kind    = UPD_NONE;
      tgt_idx = '0;
    end else if (hit_any) begin
      kind    = UPD_HIT;
      tgt_idx = hit_idx;
    end else if (free_any) begin
      kind    = UPD_FILL;
      tgt_idx = free_idx;
    end else begin
      kind    = UPD_EVICT;
      tgt_idx = vic_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ent_valid <= '0;
      ent_page  <= '0;
      ent_count <= '0;
    end else begin
      case (kind)
        UPD_HIT: begin
          if (ent_count[tgt_idx] != CNT_MAX)
            ent_count[tgt_idx] <= ent_count[tgt_idx] + 1'b1;
        end
        UPD_FILL, UPD_EVICT: begin
          ent_valid[tgt_idx] <= 1'b1;
          ent_page[tgt_idx]  <= upd_page;
          ent_count[tgt_idx] <= {{(CNT_W-1){1'b0}}, 1'b1};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hpt_rank_select.sv
module hpt_rank_select #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 8,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int REM_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0]            cand,
  input  logic [ENTRIES-1:0][CNT_W-1:0] counts,
  output logic                          found,
  output logic [IW-1:0]                 idx,
  output logic [REM_W-1:0]              remaining
);
  logic [CNT_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (cand[i] && (!found || counts[i] > best)) begin
        found = 1'b1;
        idx   = i[IW-1:0];
        best  = counts[i];
      end
    end
  end

  assign remaining = REM_W'($countones(cand));
endmodule

// File: rtl/hot_page_tracker.sv
module hot_page_tracker
  import hpt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int ENTRIES  = 8,
  parameter int CNT_W    = 8,
  parameter int HOT_MAX  = 4,
  parameter int EPOCH_W  = 32,
  localparam int PN_W    = ADDR_W - MP_OFFSET_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [EPOCH_W-1:0] epoch_len,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               epoch_done,
  output logic               hot_valid,
  input  logic               hot_ready,
  output logic [PN_W-1:0]    hot_page,
  output logic [CNT_W-1:0]   hot_count,
  output logic               hot_last
);
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int REM_W = $clog2(ENTRIES + 1);
  localparam int NE_W  = $clog2(HOT_MAX + 1);

  logic [PN_W-1:0]        req_page;
  logic [MP_OFFSET_W-1:0] req_offset_unused;
  assign req_page          = req_addr[ADDR_W-1:MP_OFFSET_W];
  assign req_offset_unused = req_addr[MP_OFFSET_W-1:0];

  logic                                act;
  logic                                draining;
  logic [ENTRIES-1:0]                  emitted;
  logic [NE_W-1:0]                     n_emit;
  logic                                tick;
  logic [1:0]                          bk_clr;
  logic [1:0][ENTRIES-1:0]             bk_valid;
  logic [1:0][ENTRIES-1:0][PN_W-1:0]   bk_page;
  logic [1:0][ENTRIES-1:0][CNT_W-1:0]  bk_count;

  hpt_epoch_timer #(.EPOCH_W(EPOCH_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .len  (epoch_len),
    .hold (draining),
    .tick (tick)
  );

  logic drain_end;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic upd_here;
    assign upd_here  = req_valid && (act == b[0]);
    assign bk_clr[b] = drain_end && (act != b[0]);
    hpt_count_bank #(
      .ENTRIES (ENTRIES),
      .PN_W    (PN_W),
      .CNT_W   (CNT_W)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .clr       (bk_clr[b]),
      .upd_en    (upd_here),
      .upd_page  (req_page),
      .ent_valid (bk_valid[b]),
      .ent_page  (bk_page[b]),
      .ent_count (bk_count[b])
    );
  end

  logic [ENTRIES-1:0]            fz_valid;
  logic [ENTRIES-1:0][PN_W-1:0]  fz_page;
  logic [ENTRIES-1:0][CNT_W-1:0] fz_count;
  logic [ENTRIES-1:0]            cand;
  logic                          sel_found;
  logic [IW-1:0]                 sel_idx;
  logic [REM_W-1:0]              remaining;

  assign fz_valid = bk_valid[!act];
  assign fz_page  = bk_page[!act];
  assign fz_count = bk_count[!act];
  assign cand     = fz_valid & ~emitted;

  hpt_rank_select #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_rank (
    .cand      (cand),
    .counts    (fz_count),
    .found     (sel_found),
    .idx       (sel_idx),
    .remaining (remaining)
  );

  logic quota_left, slot_free, accept_last, can_emit, next_last;

  assign quota_left  = n_emit < NE_W'(HOT_MAX);
  assign slot_free   = !hot_valid || hot_ready;
  assign accept_last = hot_valid && hot_ready && hot_last;
  assign drain_end   = draining &&
                       (accept_last || (!hot_valid && !(sel_found && quota_left)));
  assign can_emit    = draining && slot_free && !accept_last && sel_found && quota_left;
  assign next_last   = (({1'b0, n_emit} + 1'b1) == (NE_W + 1)'(HOT_MAX)) ||
                       (remaining == REM_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      act        <= 1'b0;
      draining   <= 1'b0;
      emitted    <= '0;
      n_emit     <= '0;
      epoch_done <= 1'b0;
      hot_valid  <= 1'b0;
      hot_page   <= '0;
      hot_count  <= '0;
      hot_last   <= 1'b0;
    end else begin
      epoch_done <= tick;
      if (tick) begin
        act      <= !act;
        draining <= 1'b1;
        emitted  <= '0;
        n_emit   <= '0;
      end else if (drain_end) begin
        draining  <= 1'b0;
        hot_valid <= 1'b0;
        hot_last  <= 1'b0;
      end else if (can_emit) begin
        hot_valid        <= 1'b1;
        hot_page         <= fz_page[sel_idx];
        hot_count        <= fz_count[sel_idx];
        hot_last         <= next_last;
        emitted[sel_idx] <= 1'b1;
        n_emit           <= n_emit + 1'b1;
      end else if (hot_valid && hot_ready) begin
        hot_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpt_checker.sv
module hpt_checker #(
  parameter int PN_W  = 22,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             epoch_done,
  input logic             hot_valid,
  input logic             hot_ready,
  input logic [PN_W-1:0]  hot_page,
  input logic [CNT_W-1:0] hot_count,
  input logic             hot_last
);
  // R6
  epoch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    epoch_done |=> !epoch_done);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hot_valid && !hot_ready) |=> (hot_valid && $stable(hot_page) &&
                                   $stable(hot_count) && $stable(hot_last)));

  // R7
  rank_order_chk: assert property (@(posedge clk) disable iff (rst)
    (hot_valid && hot_ready && !hot_last) |=>
      (hot_valid && (hot_count <= $past(hot_count))));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!hot_valid && !epoch_done));

  // R12
  boundary_idle_chk: assert property (@(posedge clk) disable iff (rst)
    epoch_done |-> !hot_valid);
endmodule

bind hot_page_tracker hpt_checker #(.PN_W(PN_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .epoch_done (epoch_done),
  .hot_valid  (hot_valid),
  .hot_ready  (hot_ready),
  .hot_page   (hot_page),
  .hot_count  (hot_count),
  .hot_last   (hot_last)
);

// File: tb/hot_page_tracker_test.sv
`timescale 1ns/1ps
module hot_page_tracker_test;
  localparam int ADDR_W  = 32;
  localparam int ENTRIES = 8;
  localparam int CNT_W   = 8;
  localparam int HOT_MAX = 4;
  localparam int EPOCH_W = 32;
  localparam int PN_W    = ADDR_W - 10;
  localparam int CMAX    = (1 << CNT_W) - 1;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [EPOCH_W-1:0] epoch_len = 32'd60;
  logic               req_valid = 1'b0;
  logic [ADDR_W-1:0]  req_addr = '0;
  logic               hot_ready = 1'b1;
  logic               epoch_done, hot_valid, hot_last;
  logic [PN_W-1:0]    hot_page;
  logic [CNT_W-1:0]   hot_count;

  always #10 clk = !clk;

  hot_page_tracker #(
    .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .CNT_W(CNT_W),
    .HOT_MAX(HOT_MAX), .EPOCH_W(EPOCH_W)
  ) uut (
    .clk(clk), .rst(rst), .epoch_len(epoch_len),
    .req_valid(req_valid), .req_addr(req_addr),
    .epoch_done(epoch_done), .hot_valid(hot_valid), .hot_ready(hot_ready),
    .hot_page(hot_page), .hot_count(hot_count), .hot_last(hot_last)
  );

  int checks = 0;
  int failures = 0;
  string tag = "R11";

  task automatic chk(input bit ok, input string t, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  // Bench model of the live table, timer and readout
  bit mv[ENTRIES];
  int mp[ENTRIES];
  int mc[ENTRIES];
  int cnt_m = 0;
  bit m_drain = 0;
  bit m_done = 0;
  int exp_p[HOT_MAX];
  int exp_c[HOT_MAX];
  int exp_n = 0;
  int m_acc = 0;
  bit was_stall = 0;
  int st_page, st_cnt, st_last;

  function automatic void model_clear();
    for (int i = 0; i < ENTRIES; i++) begin
      mv[i] = 0; mp[i] = 0; mc[i] = 0;
    end
  endfunction

  function automatic void model_req(input int pg);
    int t;
    t = -1;
    for (int i = 0; i < ENTRIES; i++) if (t < 0 && mv[i] && mp[i] == pg) t = i;
    if (t >= 0) begin
      if (mc[t] < CMAX) mc[t]++;
      return;
    end
    for (int i = 0; i < ENTRIES; i++) if (t < 0 && !mv[i]) t = i;
    if (t < 0) begin
      t = 0;
      for (int i = 1; i < ENTRIES; i++) if (mc[i] < mc[t]) t = i;
    end
    mv[t] = 1; mp[t] = pg; mc[t] = 1;
  endfunction

  function automatic void model_snapshot();
    bit used[ENTRIES];
    int b;
    for (int i = 0; i < ENTRIES; i++) used[i] = 0;
    exp_n = 0;
    for (int k = 0; k < HOT_MAX; k++) begin
      b = -1;
      for (int i = 0; i < ENTRIES; i++)
        if (mv[i] && !used[i] && (b < 0 || mc[i] > mc[b])) b = i;
      if (b >= 0) begin
        used[b] = 1; exp_p[exp_n] = mp[b]; exp_c[exp_n] = mc[b]; exp_n++;
      end
    end
  endfunction

  always @(negedge clk) begin
    bit hold, term, acc;
    // R6 and R10: pulse position follows the model timer
    chk(epoch_done == m_done, "R6", "epoch_done", int'(epoch_done), int'(m_done));
    if (hot_valid && was_stall) begin
      // R8
      chk(int'(hot_page) == st_page && int'(hot_count) == st_cnt &&
          int'(hot_last) == st_last, "R8", "held entry page", int'(hot_page), st_page);
    end
    if (hot_valid && hot_ready) begin
      if (m_acc < exp_n) begin
        chk(int'(hot_page) == exp_p[m_acc], tag, "hot_page", int'(hot_page), exp_p[m_acc]);
        chk(int'(hot_count) == exp_c[m_acc], tag, "hot_count", int'(hot_count), exp_c[m_acc]);
        chk(int'(hot_last) == int'(m_acc + 1 == exp_n), tag, "hot_last",
            int'(hot_last), int'(m_acc + 1 == exp_n));
      end else begin
        chk(1'b0, tag, "unexpected entry", int'(hot_page), -1);
      end
    end
    was_stall = hot_valid && !hot_ready;
    st_page = int'(hot_page); st_cnt = int'(hot_count); st_last = int'(hot_last);

    if (rst) begin
      model_clear();
      cnt_m = 0; m_drain = 0; m_done = 0; exp_n = 0; m_acc = 0;
    end else begin
      hold = m_drain;
      term = (longint'(cnt_m) + 1 >= longint'(epoch_len));
      acc  = hot_valid && hot_ready;
      if (req_valid) model_req(int'(req_addr >> 10));
      m_done = 0;
      if (m_drain) begin
        if (exp_n == 0) m_drain = 0;
        else if (acc) begin
          m_acc++;
          if (m_acc == exp_n) m_drain = 0;
        end
      end
      if (term && !hold) begin
        model_snapshot();
        model_clear();
        cnt_m = 0; m_drain = 1; m_done = 1; m_acc = 0;
      end else if (!term) begin
        cnt_m++;
      end
    end
  end

  task automatic send(input int pg, input int off);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_addr  = (ADDR_W'(pg) << 10) | ADDR_W'(off & 32'h3FF);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; req_valid = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
  endtask

  bit finished = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
      summary();
    end
  end

  initial begin
    int seed;
    int pg;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R11: outputs idle after reset
    chk(hot_valid == 1'b0, "R11", "hot_valid after reset", int'(hot_valid), 0);
    chk(epoch_done == 1'b0, "R11", "epoch_done after reset", int'(epoch_done), 0);

    // R1 / R2 / R3: offsets alias, siblings separate, hits increment, fills in order
    tag = "R1/R2/R3";
    epoch_len = 60;
    do_reset();
    send(5, 0); send(5, 'h3FF); send(5, 'h123); send(4, 7);
    send(6, 1); send(6, 2); send(7, 0); send(5, 9);
    idle(140);

    // R4: more pages than entries forces evictions
    tag = "R4";
    epoch_len = 80;
    do_reset();
    for (int p = 0; p < ENTRIES; p++)
      for (int k = 0; k <= p % 3; k++) send(100 + p, k);
    send(200, 0); send(201, 0); send(201, 1); send(202, 0);
    idle(180);

    // R5: saturation
    tag = "R5";
    epoch_len = 400;
    do_reset();
    for (int k = 0; k < 300; k++) send(9, k);
    send(10, 0);
    idle(500);

    // R12: empty windows produce no entries
    tag = "R12";
    epoch_len = 30;
    do_reset();
    idle(75);

    // R8 / R9 / R10: stalled readout stretches window; shadow table keeps counting
    tag = "R9/R10";
    epoch_len = 20;
    do_reset();
    for (int k = 0; k < 15; k++) send(30 + (k % 5), k);
    hot_ready = 1'b0;
    for (int k = 0; k < 60; k++) send(40 + (k % 3), k);
    idle(20);
    hot_ready = 1'b1;
    idle(80);

    // R7: random traffic with skewed pool and random backpressure
    tag = "R7";
    epoch_len = 150;
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      @(posedge clk); #1;
      hot_ready = ($urandom % 4) != 0;
      if (($urandom % 10) < 6) begin
        pg = ($urandom % 2 == 0) ? int'($urandom % 4) : int'($urandom % 14);
        req_valid = 1'b1;
        req_addr  = (ADDR_W'(pg + 500) << 10) | ADDR_W'($urandom % 1024);
      end else begin
        req_valid = 1'b0;
      end
    end
    hot_ready = 1'b1;
    idle(400);
    finished = 1;
    summary();
  end
endmodule